// File: doc/BRIEF.md
# Windowed Display Fetch Address Generator

This block produces the sequence of 32-bit word addresses that a display fetch engine reads for one frame. The window shown on screen may be a rectangle cut out of a wider frame buffer. When two-dimensional mode is on, the block walks a programmed number of words along a line. After the last word of that line it jumps forward by a programmed word increment to the first word of the next line. When the mode is off, it steps through memory one word at a time for the whole frame.

Software programs six staging registers over a write-only select/data port. These hold the window's first word, the bit position of the first pixel in that word, the line-to-line increment, the frame length in words, the words per line and a control word. A control write with the update bit set marks the staged values as pending. They are copied to the active set only when the next frame is accepted, so a frame is never fetched with mixed settings and the window can move from one frame to the next. Addresses leave under a valid/ready handshake as byte addresses. Each word carries line-end and frame-end marks. The active first-pixel offset is held on its own output for the pixel unpacker.

Top module: `wdma_addr_gen`

## Requirements
- R1: After reset, addr_valid, line_end, frame_end, pix_off and upd_pending are all 0, and the active frame length is 0, so a frame_start yields no words.
- R2: On the cycle after an accepted frame_start, addr_valid is 1 and addr equals the active base word address times 4, with the two low bits zero.
- R3: With the 2D enable (control bit 0) clear, each accepted word is followed by the next word address (addr + 4). The increment and words-per-line registers have no effect, and pix_off reads 0.
- R4: With 2D enable set, line_end is 1 on every word whose position in the frame is a multiple of the words-per-line count. The word after such a word is at that word's address plus the increment times 4.
- R5: Exactly frame-length words are emitted. frame_end and line_end are 1 on the last word, and addr_valid is 0 afterwards. A frame length of 0 emits nothing.
- R6: While addr_valid is 1 and addr_ready is 0, addr, line_end and frame_end hold their values.
- R7: Register writes (select 0 base, 1 offset, 2 increment, 3 length, 4 words per line, 5 control) change only staging. Writing control with bit 2 set raises upd_pending. The staged set becomes active at the next accepted frame_start, which clears upd_pending.
- R8: A frame_start while a frame is in progress is ignored, unless it comes in the cycle of the last word's handshake.
- R9: A frame_start in the cycle of the last word's handshake starts the next frame, with valid on the very next cycle and no idle gap.
- R10: An update request written in the same cycle as an accepted frame_start does not apply to that frame. upd_pending stays 1 and the staged set loads at the following frame.
- R11: With packed-24 mode (control bit 1) set, a staged offset other than 0 or 8 is loaded as 0. pix_off shows the loaded offset when 2D is enabled and 0 otherwise.
- R12: The word address wraps modulo 2^30, so the byte address wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame start pulse |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | addr holds a word to fetch |
| addr | output | 32 | Byte address of the word |
| line_end | output | 1 | Current word is the last of its line |
| frame_end | output | 1 | Current word is the last of the frame |
| pix_off | output | 5 | Active first-pixel bit offset |
| upd_pending | output | 1 | Staged settings await the next frame |

## Verification
Two pairs of events can coincide. The first is the final word's handshake and a new frame_start. The bench raises frame_start while it accepts the last word and expects the first address of the next frame on the following cycle, with no idle cycle. The second is an update request and the shadow copy at frame acceptance. The bench writes the control register in the same cycle as frame_start. It then expects the old window to be fetched with upd_pending still high, and the staged window to be fetched at the frame after. A frame_start injected mid-frame must leave the running address sequence unbroken.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic [2:0] {
      SEL_BASE = 3'd0,
      SEL_OFF  = 3'd1,
      SEL_INC  = 3'd2,
      SEL_FSZ  = 3'd3,
      SEL_WPL  = 3'd4,
      SEL_CTRL = 3'd5
   } cfg_sel_e;

   localparam int CTRL_EN2D = 0;
   localparam int CTRL_P24  = 1;
   localparam int CTRL_UPD  = 2;
endpackage

// File: rtl/wdg_off_fix.sv
module wdg_off_fix #(
   parameter int OFF_W   = 5,
   parameter bit HAS_P24 = 1'b1
) (
   input  logic [OFF_W-1:0] off_in,
   input  logic             p24,
   output logic [OFF_W-1:0] off_out
);
   generate
      if (OFF_W < 4) begin : g_bad_w
         $error("wdg_off_fix: OFF_W must be at least 4");
      end
      if (HAS_P24) begin : g_p24
         always_comb begin
            if (p24 && (off_in != OFF_W'(0)) && (off_in != OFF_W'(8)))
               off_out = '0;
            else
               off_out = off_in;
         end
         always_comb begin
            if (p24 === 1'b1)
               AST_P24_LEGAL: assert (off_out == OFF_W'(0) || off_out == OFF_W'(8)); // R11
         end
      end else begin : g_raw
         logic unused_p24;
         assign unused_p24 = p24;
         assign off_out    = off_in;
      end
   endgenerate
endmodule

// File: rtl/wdg_cfg.sv
module wdg_cfg
   import wdg_pkg::*;
#(
   parameter int CFG_DW  = 32,
   parameter int WA_W    = 30,
   parameter int INC_W   = 12,
   parameter int FSZ_W   = 16,
   parameter int LPL_W   = 12,
   parameter int OFF_W   = 5,
   parameter bit HAS_P24 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [2:0]        sel,
   input  logic [CFG_DW-1:0] wdata,
   input  logic              go,
   output logic [WA_W-1:0]   nxt_base,
   output logic              nxt_fsz_nz,
   output logic [WA_W-1:0]   act_base,
   output logic [INC_W-1:0]  act_inc,
   output logic [FSZ_W-1:0]  act_fsz,
   output logic [LPL_W-1:0]  act_wpl,
   output logic              act_en2d,
   output logic [OFF_W-1:0]  act_off,
   output logic              pending
);
   logic [WA_W-1:0]  s_base;
   logic [OFF_W-1:0] s_off;
   logic [INC_W-1:0] s_inc;
   logic [FSZ_W-1:0] s_fsz;
   logic [LPL_W-1:0] s_wpl;
   logic             s_en2d, s_p24;
   logic [OFF_W-1:0] fixed_off, s_eff_off;
   logic             upd_req;
   cfg_sel_e         sel_e;

   assign sel_e   = cfg_sel_e'(sel);
   assign upd_req = we && (sel_e == SEL_CTRL) && wdata[CTRL_UPD];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_base <= '0; s_off <= '0; s_inc <= '0; s_fsz <= '0;
         s_wpl  <= '0; s_en2d <= 1'b0; s_p24 <= 1'b0;
      end else if (we) begin
         case (sel_e)
            SEL_BASE: s_base <= wdata[WA_W-1:0];
            SEL_OFF:  s_off  <= wdata[OFF_W-1:0];
            SEL_INC:  s_inc  <= wdata[INC_W-1:0];
            SEL_FSZ:  s_fsz  <= wdata[FSZ_W-1:0];
            SEL_WPL:  s_wpl  <= wdata[LPL_W-1:0];
            SEL_CTRL: begin
               s_en2d <= wdata[CTRL_EN2D];
               s_p24  <= wdata[CTRL_P24];
            end
            default: ;
         endcase
      end
   end

   wdg_off_fix #(.OFF_W(OFF_W), .HAS_P24(HAS_P24)) u_fix (
      .off_in (s_off),
      .p24    (s_p24),
      .off_out(fixed_off)
   );

   assign s_eff_off = s_en2d ? fixed_off : '0;

   assign nxt_base   = pending ? s_base : act_base;
   assign nxt_fsz_nz = pending ? (s_fsz != '0) : (act_fsz != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_base <= '0; act_inc <= '0; act_fsz <= '0; act_wpl <= '0;
         act_en2d <= 1'b0; act_off <= '0;
      end else if (go && pending) begin
         act_base <= s_base;
         act_inc  <= s_inc;
         act_fsz  <= s_fsz;
         act_wpl  <= s_wpl;
         act_en2d <= s_en2d;
         act_off  <= s_eff_off;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       pending <= 1'b0;
      else if (upd_req) pending <= 1'b1;
      else if (go)      pending <= 1'b0;
   end

   AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pending && !go |=> pending); // R7
   AST_LOAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      go && !upd_req |=> !pending); // R7
   AST_SAME_CYCLE_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      go && upd_req |=> pending); // R10
   AST_ACT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> $stable(act_base) && $stable(act_fsz) && $stable(act_inc)); // R7
endmodule

// File: rtl/wdg_walk.sv
module wdg_walk #(
   parameter int WA_W  = 30,
   parameter int INC_W = 12,
   parameter int FSZ_W = 16,
   parameter int LPL_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             ready,
   input  logic [WA_W-1:0]  nxt_base,
   input  logic             nxt_fsz_nz,
   input  logic [INC_W-1:0] act_inc,
   input  logic [FSZ_W-1:0] act_fsz,
   input  logic [LPL_W-1:0] act_wpl,
   input  logic             act_en2d,
   output logic             go,
   output logic             valid,
   output logic [WA_W-1:0]  addr_w,
   output logic             line_end,
   output logic             frame_end
);
   logic             run;
   logic [WA_W-1:0]  addr_q;
   logic [FSZ_W-1:0] wcnt;
   logic [LPL_W-1:0] lcnt;
   logic             wcnt_last, lcnt_last, hs, fin, jump;

   assign wcnt_last = ({1'b0, wcnt} + (FSZ_W+1)'(1)) == {1'b0, act_fsz};
   assign lcnt_last = ({1'b0, lcnt} + (LPL_W+1)'(1)) == {1'b0, act_wpl};
   assign hs        = run && ready;
   assign fin       = hs && wcnt_last;
   assign go        = frame_start && (!run || fin);
   assign jump      = act_en2d && lcnt_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run    <= 1'b0;
         addr_q <= '0;
         wcnt   <= '0;
         lcnt   <= '0;
      end else if (go) begin
         run    <= nxt_fsz_nz;
         addr_q <= nxt_base;
         wcnt   <= '0;
         lcnt   <= '0;
      end else if (hs) begin
         if (wcnt_last) begin
            run <= 1'b0;
         end else begin
            wcnt <= wcnt + FSZ_W'(1);
            if (jump) begin
               addr_q <= addr_q + WA_W'(act_inc);
               lcnt   <= '0;
            end else begin
               addr_q <= addr_q + WA_W'(1);
               lcnt   <= lcnt + LPL_W'(1);
            end
         end
      end
   end

   assign valid     = run;
   assign addr_w    = addr_q;
   assign frame_end = run && wcnt_last;
   assign line_end  = run && (wcnt_last || jump);

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(addr_w) && $stable(line_end)); // R6
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      valid && ready && !line_end |=> valid && (addr_w == $past(addr_w) + WA_W'(1))); // R3
   AST_LINE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      valid && ready && line_end && !frame_end
      |=> addr_w == $past(addr_w) + WA_W'($past(act_inc))); // R4
   AST_FE_IS_LE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> line_end); // R5
   AST_END_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      valid && ready && frame_end && !frame_start |=> !valid); // R5
   AST_MID_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !frame_end && frame_start |=> valid); // R8
endmodule

// File: rtl/wdma_addr_gen.sv
module wdma_addr_gen #(
   parameter int ADDR_W    = 32,
   parameter int CFG_DW    = 32,
   parameter int WORD_BITS = 32,
   parameter int INC_W     = 12,
   parameter int FSZ_W     = 16,
   parameter int LPL_W     = 12,
   parameter bit HAS_P24   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [CFG_DW-1:0] cfg_wdata,
   input  logic              frame_start,
   input  logic              addr_ready,
   output logic              addr_valid,
   output logic [ADDR_W-1:0] addr,
   output logic              line_end,
   output logic              frame_end,
   output logic [$clog2(WORD_BITS)-1:0] pix_off,
   output logic              upd_pending
);
   localparam int WA_W  = ADDR_W - 2;
   localparam int OFF_W = $clog2(WORD_BITS);

   generate
      if (WORD_BITS != 32) begin : g_bad_word
         $error("wdma_addr_gen: word addressing assumes 32-bit words");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("wdma_addr_gen: ADDR_W out of range");
      end
      if (WA_W > CFG_DW || INC_W > WA_W || FSZ_W > CFG_DW || LPL_W > CFG_DW) begin : g_bad_fld
         $error("wdma_addr_gen: field wider than its register or the address");
      end
   endgenerate

   logic [WA_W-1:0]  nxt_base, act_base, addr_w;
   logic             nxt_fsz_nz, act_en2d, go;
   logic [INC_W-1:0] act_inc;
   logic [FSZ_W-1:0] act_fsz;
   logic [LPL_W-1:0] act_wpl;
   logic [OFF_W-1:0] act_off;
   logic [WA_W-1:0]  unused_base;

   wdg_cfg #(
      .CFG_DW(CFG_DW), .WA_W(WA_W), .INC_W(INC_W), .FSZ_W(FSZ_W),
      .LPL_W(LPL_W), .OFF_W(OFF_W), .HAS_P24(HAS_P24)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .go(go), .nxt_base(nxt_base), .nxt_fsz_nz(nxt_fsz_nz),
      .act_base(act_base), .act_inc(act_inc), .act_fsz(act_fsz),
      .act_wpl(act_wpl), .act_en2d(act_en2d), .act_off(act_off),
      .pending(upd_pending)
   );

   assign unused_base = act_base;

   wdg_walk #(
      .WA_W(WA_W), .INC_W(INC_W), .FSZ_W(FSZ_W), .LPL_W(LPL_W)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ready(addr_ready),
      .nxt_base(nxt_base), .nxt_fsz_nz(nxt_fsz_nz), .act_inc(act_inc),
      .act_fsz(act_fsz), .act_wpl(act_wpl), .act_en2d(act_en2d),
      .go(go), .valid(addr_valid), .addr_w(addr_w),
      .line_end(line_end), .frame_end(frame_end)
   );

   assign addr    = {addr_w, 2'b00};
   assign pix_off = act_off;

   AST_START_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      go && nxt_fsz_nz |=> addr_valid && (addr[1:0] == 2'b00)); // R2
   AST_OFF_ZERO_1D: assert property (@(posedge clk) disable iff (!rst_n)
      !act_en2d |-> pix_off == '0); // R3
endmodule

// File: tb/sim_wdma_addr_gen.sv
module sim_wdma_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        frame_start = 1'b0;
   logic        addr_ready = 1'b0;
   logic        addr_valid, line_end, frame_end, upd_pending;
   logic [31:0] addr;
   logic [4:0]  pix_off;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   wdma_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .frame_start(frame_start), .addr_ready(addr_ready),
      .addr_valid(addr_valid), .addr(addr), .line_end(line_end),
      .frame_end(frame_end), .pix_off(pix_off), .upd_pending(upd_pending)
   );

   task automatic cmp(input string req, input longint act, input longint exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int sel, input longint data);
      cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 32'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // control word: bit0 2D enable, bit1 packed-24, bit2 update
   task automatic prog(input longint base, input int off, input int inc, input int fsz,
                       input int wpl, input bit en, input bit p24, input bit upd);
      wr(0, base); wr(1, off); wr(2, inc); wr(3, fsz); wr(4, wpl);
      wr(5, {upd, p24, en});
   endtask

   task automatic start();
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
   endtask

   task automatic expect_frame(input string tg, input longint base, input int fsz,
                               input int wpl, input int inc, input bit en,
                               input int exp_off, input bit stall,
                               input bit mid_fs, input bit chain);
      int i = 0;
      int guard = 0;
      bit prev_stall = 1'b0;
      longint e = base;
      cmp({tg, " R11 pix_off"}, pix_off, exp_off);
      if (fsz == 0) begin
         cmp("R5 empty frame valid", addr_valid, 0);
         @(negedge clk);
         cmp("R5 empty frame valid later", addr_valid, 0);
         return;
      end
      while (i < fsz && guard < 400) begin
         bit rdy;
         bit lst;
         bit le;
         string t;
         guard++;
         rdy = stall ? ((guard % 3) != 0) : 1'b1;
         lst = (i == fsz - 1);
         le  = lst || (en && ((i + 1) % wpl == 0));
         t   = prev_stall ? "R6" : ((mid_fs && i == 3) ? "R8" : tg);
         cmp({t, " valid"}, addr_valid, 1);
         cmp({t, " addr"}, addr, (e & 64'h3FFF_FFFF) << 2);
         cmp({t, " line_end"}, line_end, le);
         cmp({t, " frame_end"}, frame_end, lst);
         addr_ready  = rdy;
         frame_start = (mid_fs && i == 2) || (chain && lst && rdy);
         @(negedge clk);
         frame_start = 1'b0;
         prev_stall  = !rdy;
         if (rdy) begin
            e = (en && ((i + 1) % wpl == 0)) ? e + inc : e + 1;
            i++;
         end
      end
      addr_ready = 1'b0;
      cmp({tg, " R5 word count"}, i, fsz);
      if (!chain) cmp({tg, " R5 valid after end"}, addr_valid, 0);
   endtask

   initial begin
      #(4 * 200000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog all-requirements actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int incs[3] = '{0, 2, 7};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      cmp("R1 valid", addr_valid, 0);
      cmp("R1 line_end", line_end, 0);
      cmp("R1 frame_end", frame_end, 0);
      cmp("R1 pix_off", pix_off, 0);
      cmp("R1 pending", upd_pending, 0);
      start();
      cmp("R1 no words with reset config", addr_valid, 0);

      // R12 wrap
      prog(64'h3FFF_FFFE, 0, 0, 4, 4, 0, 0, 1);
      cmp("R7 pending set", upd_pending, 1);
      start();
      cmp("R7 pending cleared", upd_pending, 0);
      expect_frame("R12", 64'h3FFF_FFFE, 4, 4, 0, 0, 0, 0, 0, 0);

      // sweep R3 / R4 / R5
      for (int en = 0; en < 2; en++)
         for (int wpl = 1; wpl < 4; wpl++)
            for (int k = 0; k < 3; k++)
               for (int fsz = 0; fsz < 8; fsz++) begin
                  longint b = 100 + fsz * 16 + wpl + k * 1000;
                  prog(b, 5, incs[k], fsz, wpl, en[0], 0, 1);
                  start();
                  expect_frame(en ? "R4" : "R3", b, fsz, wpl, incs[k], en[0],
                               en ? 5 : 0, fsz[0], 0, 0);
               end

      // R7 staging without update
      prog(40, 0, 0, 3, 3, 0, 0, 1);
      start();
      expect_frame("R7", 40, 3, 3, 0, 0, 0, 0, 0, 0);
      prog(900, 0, 0, 5, 3, 0, 0, 0);
      cmp("R7 no pending without update", upd_pending, 0);
      start();
      expect_frame("R7", 40, 3, 3, 0, 0, 0, 0, 0, 0);
      wr(5, 3'b100);
      start();
      expect_frame("R7", 900, 5, 3, 0, 0, 0, 0, 0, 0);

      // R8 mid-frame start ignored
      prog(60, 0, 3, 6, 2, 1, 0, 1);
      start();
      expect_frame("R8", 60, 6, 2, 3, 1, 0, 0, 1, 0);

      // R9 back-to-back
      prog(200, 0, 0, 3, 3, 0, 0, 1);
      start();
      expect_frame("R9", 200, 3, 3, 0, 0, 0, 1, 0, 1);
      expect_frame("R9", 200, 3, 3, 0, 0, 0, 0, 0, 0);

      // R10 update written in the cycle of frame acceptance
      prog(300, 0, 0, 2, 2, 0, 0, 0);
      cfg_we = 1'b1; cfg_sel = 3'd5; cfg_wdata = 32'h4; frame_start = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; frame_start = 1'b0;
      cmp("R10 pending kept", upd_pending, 1);
      expect_frame("R10", 200, 3, 3, 0, 0, 0, 0, 0, 0);
      start();
      cmp("R10 pending cleared at next frame", upd_pending, 0);
      expect_frame("R10", 300, 2, 2, 0, 0, 0, 0, 0, 0);

      // R11 packed-24 offset legalisation
      prog(10, 5, 1, 2, 1, 1, 1, 1);
      start();
      expect_frame("R11", 10, 2, 1, 1, 1, 0, 0, 0, 0);
      prog(10, 8, 1, 2, 1, 1, 1, 1);
      start();
      expect_frame("R11", 10, 2, 1, 1, 1, 8, 0, 0, 0);
      prog(10, 8, 1, 2, 1, 0, 1, 1);
      start();
      expect_frame("R11", 10, 2, 1, 1, 0, 0, 0, 0, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule